// File: doc/BRIEF.md
# Intersection Signal Sequencer with Pedestrian Interval

This block sequences the lamps of a crossing between a main street and a side street. It has five phases: main green, main yellow, side green, side yellow, and an all-red interval for pedestrians. Every duration is counted in ticks of a one-cycle enable, `tick`, which the chip supplies at one pulse per second. The long interval, the yellow interval and the all-red interval are parameters, so a small configuration can be simulated quickly.

Main green is the resting phase. The side street gets green only when the vehicle sensor reports a car and the long interval has run out. A pedestrian button press is caught in a one-cycle pulse and held until it is served. The press ends whichever green is showing, goes through that street's yellow, and then opens an all-red interval. After the all-red interval the controller always returns to main green. A press that arrives while a yellow is showing restarts the yellow count.

All pins are plain level control signals. The block has no data stream, so there is no handshake and no back-pressure.

Top module: `xing_light_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the block in main green, with the main green lamp and the side red lamp lit, clears all interval counts and drops any stored pedestrian press.
- R2: In main green, with `side_car` low and no pedestrian press, the phase never changes, however many ticks arrive.
- R3: In main green, with `side_car` high and no press, the phase moves to main yellow on the first clock edge after the LONG_TICKS-th tick counted since main green was entered.
- R4: A yellow phase lasts SHORT_TICKS ticks when no press arrives during it. With no press stored, main yellow then moves to side green and side yellow moves to main green.
- R5: Side green moves to side yellow after LONG_TICKS ticks. It also moves on the clock edge after any cycle in which `side_car` is low.
- R6: A `walk_req` seen in main green moves the phase to main yellow on that same clock edge. When the yellow ends, the phase goes to all-red and not to side green.
- R7: A `walk_req` seen in side green moves the phase to side yellow on that same clock edge. When the yellow ends, the phase goes to all-red.
- R8: In all-red both streets show only red for WALK_TICKS ticks. The phase then moves to main green.
- R9: A `walk_req` seen in either yellow phase restarts the yellow count from zero. The yellow then lasts SHORT_TICKS more ticks before it moves to all-red.
- R10: A `walk_req` seen during all-red is ignored. After the all-red interval, main green holds as if no press had been made.
- R11: A one-cycle `walk_req` is stored until the all-red phase is entered. A press made during a yellow that was started by the vehicle path therefore leads to all-red, not to the other street's green.
- R12: Each street has exactly one lamp lit in every cycle. The two streets are never non-red at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle timebase pulse (one per second in use) |
| side_car | input | 1 | Side-street vehicle present |
| walk_req | input | 1 | Pedestrian press, may be a single cycle |
| main_red | output | 1 | Main street red lamp |
| main_yel | output | 1 | Main street yellow lamp |
| main_grn | output | 1 | Main street green lamp |
| side_red | output | 1 | Side street red lamp |
| side_yel | output | 1 | Side street yellow lamp |
| side_grn | output | 1 | Side street green lamp |

## Verification
The assertions check the following on every cycle:
- exactly one lamp is lit on each street, and the two streets are never green or yellow together;
- a press seen in either green ends that green on the next edge;
- a missing car ends side green;
- a press during main yellow holds the yellow for at least one more cycle;
- the phases that may follow main yellow and all-red are the only ones that do.

Tick-counted durations need the bench's scenarios. These cover how long each phase holds and the choice between all-red and the other green after a yellow, which depends on a stored press. They also cover the yellow restart and the ignoring of presses during all-red. The bench sweeps the tick position at which a press arrives across the whole green interval.

// File: rtl/xing_light_pkg.sv
package xing_light_pkg;
  typedef enum logic [2:0] {
    PH_MAIN_GO   = 3'd0,
    PH_MAIN_WARN = 3'd1,
    PH_SIDE_GO   = 3'd2,
    PH_SIDE_WARN = 3'd3,
    PH_ALL_STOP  = 3'd4
  } phase_e;

  typedef struct packed {
    logic red;
    logic yel;
    logic grn;
  } lamp_t;
endpackage

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  assign done = (cnt_q == LIM);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      cnt_q <= '0;
    end else if (tick && !done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/walk_latch.sv
module walk_latch (
  input  logic clk,
  input  logic rst,
  input  logic walk_req,
  input  logic accept,
  input  logic serve,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst || serve) begin
      pend <= 1'b0;
    end else if (walk_req && accept) begin
      pend <= 1'b1;
    end
  end
endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
  import xing_light_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   side_car,
  input  logic   walk_req,
  input  logic   pend,
  input  logic   long_done,
  input  logic   short_done,
  input  logic   walk_done,
  output phase_e phase_q,
  output logic   change,
  output logic   retrig,
  output logic   enter_stop
);
  phase_e phase_d;
  logic   press_now;

  assign press_now  = pend || walk_req;
  assign change     = (phase_d != phase_q);
  assign enter_stop = change && (phase_d == PH_ALL_STOP);

  always_comb begin
    phase_d = phase_q;
    retrig  = 1'b0;
    unique case (phase_q)
      PH_MAIN_GO: begin
        if (press_now || (long_done && side_car)) phase_d = PH_MAIN_WARN;
      end
      PH_MAIN_WARN: begin
        if (walk_req)        retrig  = 1'b1;
        else if (short_done) phase_d = pend ? PH_ALL_STOP : PH_SIDE_GO;
      end
      PH_SIDE_GO: begin
        if (press_now || long_done || !side_car) phase_d = PH_SIDE_WARN;
      end
      PH_SIDE_WARN: begin
        if (walk_req)        retrig  = 1'b1;
        else if (short_done) phase_d = pend ? PH_ALL_STOP : PH_MAIN_GO;
      end
      PH_ALL_STOP: begin
        if (walk_done) phase_d = PH_MAIN_GO;
      end
      default: phase_d = PH_MAIN_GO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_MAIN_GO;
    else     phase_q <= phase_d;
  end
endmodule

// File: rtl/lamp_decode.sv
module lamp_decode
  import xing_light_pkg::*;
(
  input  phase_e phase,
  output lamp_t  main_l,
  output lamp_t  side_l
);
  always_comb begin
    main_l = '{red: 1'b1, yel: 1'b0, grn: 1'b0};
    side_l = '{red: 1'b1, yel: 1'b0, grn: 1'b0};
    unique case (phase)
      PH_MAIN_GO:   main_l = '{red: 1'b0, yel: 1'b0, grn: 1'b1};
      PH_MAIN_WARN: main_l = '{red: 1'b0, yel: 1'b1, grn: 1'b0};
      PH_SIDE_GO:   side_l = '{red: 1'b0, yel: 1'b0, grn: 1'b1};
      PH_SIDE_WARN: side_l = '{red: 1'b0, yel: 1'b1, grn: 1'b0};
      default: ;
    endcase
  end
endmodule

// File: rtl/xing_light_ctrl.sv
module xing_light_ctrl
  import xing_light_pkg::*;
#(
  parameter int LONG_TICKS  = 25,
  parameter int SHORT_TICKS = 4,
  parameter int WALK_TICKS  = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic side_car,
  input  logic walk_req,
  output logic main_red,
  output logic main_yel,
  output logic main_grn,
  output logic side_red,
  output logic side_yel,
  output logic side_grn
);
  phase_e phase;
  logic   change, retrig, enter_stop, pend;
  logic   long_done, short_done, walk_done;
  logic   in_green, in_yellow, in_stop;
  lamp_t  main_l, side_l;

  assign in_green  = (phase == PH_MAIN_GO)   || (phase == PH_SIDE_GO);
  assign in_yellow = (phase == PH_MAIN_WARN) || (phase == PH_SIDE_WARN);
  assign in_stop   = (phase == PH_ALL_STOP);

  interval_timer #(.LIMIT(LONG_TICKS)) u_long (
    .clk(clk), .rst(rst), .run(in_green), .restart(change),
    .tick(tick), .done(long_done)
  );

  interval_timer #(.LIMIT(SHORT_TICKS)) u_short (
    .clk(clk), .rst(rst), .run(in_yellow), .restart(change || retrig),
    .tick(tick), .done(short_done)
  );

  interval_timer #(.LIMIT(WALK_TICKS)) u_walk (
    .clk(clk), .rst(rst), .run(in_stop), .restart(change),
    .tick(tick), .done(walk_done)
  );

  walk_latch u_latch (
    .clk(clk), .rst(rst), .walk_req(walk_req), .accept(!in_stop),
    .serve(enter_stop), .pend(pend)
  );

  phase_fsm u_fsm (
    .clk(clk), .rst(rst), .side_car(side_car), .walk_req(walk_req && !in_stop),
    .pend(pend), .long_done(long_done), .short_done(short_done),
    .walk_done(walk_done), .phase_q(phase), .change(change),
    .retrig(retrig), .enter_stop(enter_stop)
  );

  lamp_decode u_lamps (
    .phase(phase), .main_l(main_l), .side_l(side_l)
  );

  assign main_red = main_l.red;
  assign main_yel = main_l.yel;
  assign main_grn = main_l.grn;
  assign side_red = side_l.red;
  assign side_yel = side_l.yel;
  assign side_grn = side_l.grn;
endmodule

// File: rtl/xing_light_checks.sv
module xing_light_checks (
  input logic clk,
  input logic rst,
  input logic side_car,
  input logic walk_req,
  input logic main_red,
  input logic main_yel,
  input logic main_grn,
  input logic side_red,
  input logic side_yel,
  input logic side_grn
);
  AST_MAIN_ONE_LAMP: assert property (@(posedge clk) disable iff (rst) $countones({main_red, main_yel, main_grn}) == 1); // R12
  AST_SIDE_ONE_LAMP: assert property (@(posedge clk) disable iff (rst) $countones({side_red, side_yel, side_grn}) == 1); // R12
  AST_NO_CROSS_GO: assert property (@(posedge clk) disable iff (rst) !((main_grn || main_yel) && (side_grn || side_yel))); // R12
  AST_MAIN_PRESS_ENDS: assert property (@(posedge clk) disable iff (rst) (main_grn && walk_req) |=> main_yel); // R6
  AST_SIDE_PRESS_ENDS: assert property (@(posedge clk) disable iff (rst) (side_grn && walk_req) |=> side_yel); // R7
  AST_SIDE_EMPTY_ENDS: assert property (@(posedge clk) disable iff (rst) (side_grn && !side_car) |=> side_yel); // R5
  AST_YEL_RESTART_HOLDS: assert property (@(posedge clk) disable iff (rst) (main_yel && walk_req) |=> main_yel); // R9
  AST_MAIN_WARN_NEXT: assert property (@(posedge clk) disable iff (rst) $fell(main_yel) |-> (side_grn || (main_red && side_red))); // R4
  AST_STOP_EXIT_MAIN: assert property (@(posedge clk) disable iff (rst) $fell(main_red && side_red) |-> main_grn); // R8
endmodule

bind xing_light_ctrl xing_light_checks u_chk (
  .clk(clk), .rst(rst), .side_car(side_car), .walk_req(walk_req),
  .main_red(main_red), .main_yel(main_yel), .main_grn(main_grn),
  .side_red(side_red), .side_yel(side_yel), .side_grn(side_grn)
);

// File: tb/xing_light_ctrl_bench.sv
`timescale 1ns/1ps
module xing_light_ctrl_bench;
  localparam int LT = 5;
  localparam int ST = 2;
  localparam int WT = 3;
  localparam logic [5:0] MG = 6'b001100;
  localparam logic [5:0] MY = 6'b010100;
  localparam logic [5:0] SG = 6'b100001;
  localparam logic [5:0] SY = 6'b100010;
  localparam logic [5:0] AR = 6'b100100;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, side_car = 1'b0, walk_req = 1'b0;
  logic main_red, main_yel, main_grn, side_red, side_yel, side_grn;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  xing_light_ctrl #(.LONG_TICKS(LT), .SHORT_TICKS(ST), .WALK_TICKS(WT)) u_xing_light_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .side_car(side_car), .walk_req(walk_req),
    .main_red(main_red), .main_yel(main_yel), .main_grn(main_grn),
    .side_red(side_red), .side_yel(side_yel), .side_grn(side_grn)
  );

  task automatic expect_l(input logic [5:0] exp, input string tag);
    logic [5:0] act;
    act = {main_red, main_yel, main_grn, side_red, side_yel, side_grn};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: lamps=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick = 1'b0; walk_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // one tick pulse, one settle cycle, then sample point
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic press();
    @(negedge clk) walk_req = 1'b1;
    @(negedge clk) walk_req = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    @(negedge clk);
    expect_l(MG, "R1 reset main green");

    // R2 no car, no press: main green holds
    step(3 * LT);
    expect_l(MG, "R2 main green holds");

    // R3 car path duration, R4 yellow and side green, R5 side timeout
    do_reset();
    side_car = 1'b1;
    step(LT - 1);
    expect_l(MG, "R3 before long expiry");
    step(1);
    expect_l(MY, "R3 main yellow after long");
    step(ST - 1);
    expect_l(MY, "R4 main yellow held");
    step(1);
    expect_l(SG, "R4 side green after yellow");
    step(LT - 1);
    expect_l(SG, "R5 side green held");
    step(1);
    expect_l(SY, "R5 side yellow after long");
    step(ST);
    expect_l(MG, "R4 side yellow to main green");

    // R5 early end of side green when car leaves
    do_reset();
    side_car = 1'b1;
    step(LT + ST);
    expect_l(SG, "R5 reached side green");
    @(negedge clk) side_car = 1'b0;
    @(negedge clk);
    expect_l(SY, "R5 no car ends side green");

    // R6 and R8 sweep: press at each tick position in main green
    for (int k = 0; k < LT; k++) begin
      do_reset();
      side_car = 1'b0;
      step(k);
      press();
      expect_l(MY, $sformatf("R6 press at tick %0d", k));
      step(ST);
      expect_l(AR, $sformatf("R6 all red after yellow k=%0d", k));
      step(WT - 1);
      expect_l(AR, $sformatf("R8 all red held k=%0d", k));
      step(1);
      expect_l(MG, $sformatf("R8 back to main green k=%0d", k));
    end

    // R7 sweep: press at each tick position in side green
    for (int k = 0; k < LT; k++) begin
      do_reset();
      side_car = 1'b1;
      step(LT + ST);
      step(k);
      press();
      expect_l(SY, $sformatf("R7 press in side green at %0d", k));
      step(ST);
      expect_l(AR, $sformatf("R7 all red after side yellow k=%0d", k));
    end

    // R9 restart of yellow count by a press during yellow
    do_reset();
    side_car = 1'b0;
    press();
    step(ST - 1);
    press();
    step(ST - 1);
    expect_l(MY, "R9 yellow restarted");
    step(1);
    expect_l(AR, "R9 all red after restarted yellow");

    // R11 press stored during car-path yellow leads to all red, R10 press ignored in all red
    do_reset();
    side_car = 1'b1;
    step(LT);
    expect_l(MY, "R11 car-path yellow");
    press();
    step(ST);
    expect_l(AR, "R11 stored press gives all red");
    side_car = 1'b0;
    press();
    step(WT);
    expect_l(MG, "R10 all red ends normally");
    step(LT + 2);
    expect_l(MG, "R10 press during all red ignored");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule